// File: doc/BRIEF.md
# Bit-Field ALU

This block is the combinational execute core of a 32-bit integer datapath. A 4-bit operation code selects one of fifteen functions of two operands and the block returns a 32-bit result in the same cycle. Operand A always comes from a register. Operand B is already resolved upstream and is either a register value or a sign-extended immediate. The ALU does not decode instructions, generate flags or access the register file.

Besides wrap-around arithmetic, bitwise logic, shifts and rotate, the ALU handles packed bit-field work. Operand B carries the field's start bit and a length code, and its upper bits carry the value to be inserted. The block also provides a 10-bit append that builds wide constants, and a staged swap permutation ("flip"). The flip can reverse bits, nibbles, bytes or half-words, or any combination of these. Operation code 15 is not assigned. It raises an illegal-operation flag and forces the result to zero.

Top module: `bitfield_alu`

## Requirements
- R1: Code 0 returns A+B and code 2 returns A-B, both modulo 2^32.
- R2: Code 1 rotates A right by B[4:0] places. Bits 31..5 of B are ignored.
- R3: Code 3 returns A shifted left by 10 places, with B[9:0] in result bits 9..0.
- R4: Codes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT(A XOR B).
- R5: Code 8 shifts left, code 9 shifts right with zero fill, and code 10 shifts right with copies of A[31]. Each uses B[4:0] as the amount and ignores the higher bits of B.
- R6: For codes 11, 12 and 13 the field starts at bit B[4:0] of A. Its length is B[8:5], and a length code of 0 means 16 bits.
- R7: Code 11 writes the low bits of B>>10 into the field of A. All bits of A outside the field are kept. Field bits that would fall above bit 31 are dropped.
- R8: Code 12 shifts A right by the field start and keeps the low field-length bits. The top field bit is copied into every higher result bit. Bits above bit 31 of A read as zero.
- R9: Code 13 extracts the field in the same way as R8 and fills every higher result bit with zero.
- R10: Code 14 applies five swap stages to A in order: adjacent 1-bit, 2-bit, 4-bit, 8-bit and then 16-bit groups. Stage k runs only when B[k] is 1, for k from 0 to 4.
- R11: Code 15 sets the illegal flag and gives a zero result. The flag is 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see R1 to R11) |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B: register value or sign-extended immediate |
| result_o | output | 32 | Operation result |
| illegal_o | output | 1 | High when op_i is the unassigned code 15 |

## Verification
The assertions check properties of the result whenever the code applies:
- add and subtract invert back to A;
- rotating the result left by the amount recovers A;
- an AND result is a subset of both operands;
- a left shift leaves zeros below the amount;
- an insert leaves every bit outside the field unchanged;
- an extract is all zero or all sign above the field length;
- a flip keeps the bit count of A;
- an illegal code gives zero.

These properties cannot confirm exact values. The bench's reference functions confirm them: the position of an inserted field, the exact order of the flip stages, a length code of 0 standing for 16, and fields that run past bit 31.

// File: rtl/bitfield_alu_pkg.sv
`timescale 1ns/1ps
// Package: shared operation encoding for the bit-field ALU.
// Assumes a 4-bit operation code; the code values are fixed by the datapath decode.
package bitfield_alu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 4'h0,
        OP_ROR    = 4'h1,
        OP_SUB    = 4'h2,
        OP_APPEND = 4'h3,
        OP_AND    = 4'h4,
        OP_OR     = 4'h5,
        OP_XOR    = 4'h6,
        OP_XNOR   = 4'h7,
        OP_SHL    = 4'h8,
        OP_SHR    = 4'h9,
        OP_SAR    = 4'hA,
        OP_INS    = 4'hB,
        OP_SEXT   = 4'hC,
        OP_UEXT   = 4'hD,
        OP_FLIP   = 4'hE,
        OP_BAD    = 4'hF
    } alu_op_e;
endpackage

// File: rtl/alu_shift_unit.sv
`timescale 1ns/1ps
// Module: alu_shift_unit
// Computes left shift, logical and arithmetic right shift, and right rotate
// of one operand in parallel. Assumes DATA_W is a power of two, so an
// amount of SHAMT_W bits covers every bit position.
module alu_shift_unit #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  val_i,
    input  logic [SHAMT_W-1:0] amt_i,
    output logic [DATA_W-1:0]  shl_o,
    output logic [DATA_W-1:0]  shr_o,
    output logic [DATA_W-1:0]  sar_o,
    output logic [DATA_W-1:0]  ror_o
);
    logic [2*DATA_W-1:0] doubled;
    logic [2*DATA_W-1:0] doubled_sh;

    // Purpose: all four shifters share the amount and run side by side.
    always_comb begin
        shl_o      = val_i << amt_i;
        shr_o      = val_i >> amt_i;
        sar_o      = DATA_W'($signed(val_i) >>> amt_i);
        doubled    = {val_i, val_i};
        doubled_sh = doubled >> amt_i;
        ror_o      = doubled_sh[DATA_W-1:0];
    end
endmodule

// File: rtl/alu_field_unit.sv
`timescale 1ns/1ps
// Module: alu_field_unit
// Bit-field insert plus signed and unsigned extract. The field starts at
// pos_i and its length comes from len_code_i, where code 0 stands for
// 2**LEN_W bits. Assumes 2**LEN_W < DATA_W. Bits shifted beyond the top
// of the word are lost.
module alu_field_unit #(
    parameter int DATA_W   = 32,
    parameter int SHAMT_W  = $clog2(DATA_W),
    parameter int LEN_W    = 4,
    parameter int INS_W    = 22
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [SHAMT_W-1:0] pos_i,
    input  logic [LEN_W-1:0]   len_code_i,
    input  logic [INS_W-1:0]   ins_val_i,
    output logic [DATA_W-1:0]  ins_o,
    output logic [DATA_W-1:0]  sext_o,
    output logic [DATA_W-1:0]  uext_o
);
    localparam int          FLEN_W   = LEN_W + 1;
    localparam logic [FLEN_W-1:0] LEN_ZERO = FLEN_W'(2 ** LEN_W);

    logic [FLEN_W-1:0] len;
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] place_mask;
    logic [DATA_W-1:0] ins_wide;
    logic [DATA_W-1:0] a_sh;
    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] top_bit;
    logic              sign;

    // Purpose: decode the length code and build the field masks.
    always_comb begin
        len        = (len_code_i == '0) ? LEN_ZERO : {1'b0, len_code_i};
        low_mask   = ~({DATA_W{1'b1}} << len);
        place_mask = low_mask << pos_i;
    end

    // Purpose: merge the shifted insert value into A under the field mask.
    always_comb begin
        ins_wide = DATA_W'(ins_val_i) << pos_i;
        ins_o    = (a_i & ~place_mask) | (ins_wide & place_mask);
    end

    // Purpose: align the field to bit 0, then zero- or sign-fill above it.
    always_comb begin
        a_sh    = a_i >> pos_i;
        field   = a_sh & low_mask;
        top_bit = low_mask ^ (low_mask >> 1);
        sign    = |(field & top_bit);
        uext_o  = field;
        sext_o  = sign ? (field | ~low_mask) : field;
    end
endmodule

// File: rtl/alu_flip_unit.sv
`timescale 1ns/1ps
// Module: alu_flip_unit
// Staged swap permutation. Stage s exchanges adjacent groups of 2**s bits
// and runs only when ctrl_i[s] is set; the stages are applied from the
// smallest group upward. Assumes DATA_W is a power of two.
module alu_flip_unit #(
    parameter int DATA_W  = 32,
    parameter int STAGES  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [STAGES-1:0] ctrl_i,
    output logic [DATA_W-1:0] val_o
);
    logic [DATA_W-1:0] stage_q [STAGES+1];

    assign stage_q[0] = val_i;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            // Purpose: take the partner bit one group away when this stage is on.
            assign stage_q[s+1][i] = ctrl_i[s] ? stage_q[s][i ^ (1 << s)]
                                               : stage_q[s][i];
        end
    end

    assign val_o = stage_q[STAGES];
endmodule

// File: rtl/bitfield_alu.sv
`timescale 1ns/1ps
// Module: bitfield_alu (top)
// Purely combinational ALU: arithmetic, logic, shifts, rotate, 10-bit append,
// bit-field insert/extract and staged flip, selected by a 4-bit code.
// Assumes operand B was resolved upstream (register or sign-extended
// immediate). The unassigned code raises illegal_o and forces result_o to 0.
module bitfield_alu #(
    parameter int DATA_W   = 32,
    parameter int APPEND_W = 10,
    parameter int LEN_W    = 4
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] result_o,
    output logic              illegal_o
);
    import bitfield_alu_pkg::*;

    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int INS_W   = DATA_W - APPEND_W;
    localparam int LEN_LSB = SHAMT_W;
    localparam int LEN_MSB = SHAMT_W + LEN_W - 1;

    alu_op_e           op;
    logic [DATA_W-1:0] shl, shr, sar, ror;
    logic [DATA_W-1:0] ins, sext, uext;
    logic [DATA_W-1:0] flip;
    logic [DATA_W-1:0] append;

    assign op = alu_op_e'(op_i);

    alu_shift_unit #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .val_i (a_i),
        .amt_i (b_i[SHAMT_W-1:0]),
        .shl_o (shl),
        .shr_o (shr),
        .sar_o (sar),
        .ror_o (ror)
    );

    alu_field_unit #(
        .DATA_W (DATA_W),
        .SHAMT_W(SHAMT_W),
        .LEN_W  (LEN_W),
        .INS_W  (INS_W)
    ) u_field (
        .a_i        (a_i),
        .pos_i      (b_i[SHAMT_W-1:0]),
        .len_code_i (b_i[LEN_MSB:LEN_LSB]),
        .ins_val_i  (b_i[DATA_W-1:APPEND_W]),
        .ins_o      (ins),
        .sext_o     (sext),
        .uext_o     (uext)
    );

    alu_flip_unit #(.DATA_W(DATA_W), .STAGES(SHAMT_W)) u_flip (
        .val_i  (a_i),
        .ctrl_i (b_i[SHAMT_W-1:0]),
        .val_o  (flip)
    );

    // Purpose: shift A up and drop the low immediate bits of B underneath.
    assign append = (a_i << APPEND_W) | {{INS_W{1'b0}}, b_i[APPEND_W-1:0]};

    // Purpose: select the result for the operation code and flag the spare code.
    always_comb begin
        illegal_o = 1'b0;
        result_o  = '0;
        unique case (op)
            OP_ADD:    result_o = a_i + b_i;
            OP_ROR:    result_o = ror;
            OP_SUB:    result_o = a_i - b_i;
            OP_APPEND: result_o = append;
            OP_AND:    result_o = a_i & b_i;
            OP_OR:     result_o = a_i | b_i;
            OP_XOR:    result_o = a_i ^ b_i;
            OP_XNOR:   result_o = ~(a_i ^ b_i);
            OP_SHL:    result_o = shl;
            OP_SHR:    result_o = shr;
            OP_SAR:    result_o = sar;
            OP_INS:    result_o = ins;
            OP_SEXT:   result_o = sext;
            OP_UEXT:   result_o = uext;
            OP_FLIP:   result_o = flip;
            OP_BAD:    illegal_o = 1'b1;
            default:   illegal_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/bitfield_alu_checker.sv
`timescale 1ns/1ps
// Module: bitfield_alu_checker
// Property checks on the combinational ALU, attached by bind. Each check
// relates the result to the operands through an inverse or an invariant
// rather than the forward formula.
module bitfield_alu_checker #(
    parameter int DATA_W = 32
) (
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [DATA_W-1:0] result_o,
    input logic              illegal_o
);
    localparam int SHAMT_W = $clog2(DATA_W);

    logic [SHAMT_W-1:0]  amt;
    logic [SHAMT_W:0]    flen;
    logic [SHAMT_W+1:0]  fend;
    logic [2*DATA_W-1:0] rot_back;
    logic [DATA_W-1:0]   outside;
    logic [DATA_W-1:0]   above;

    // Purpose: derive the amount, field length and field span independently.
    always_comb begin
        amt      = b_i[SHAMT_W-1:0];
        flen     = (b_i[8:5] == 4'd0) ? (SHAMT_W+1)'(16) : (SHAMT_W+1)'(b_i[8:5]);
        fend     = (SHAMT_W+2)'(amt) + (SHAMT_W+2)'(flen);
        rot_back = {result_o, result_o} << amt;
        outside  = ~(({DATA_W{1'b1}} << amt) & ~({DATA_W{1'b1}} << fend));
        above    = DATA_W'($signed(result_o) >>> (flen - 1'b1));
    end

    // Purpose: per-operation invariants, evaluated whenever the inputs move.
    always_comb begin
        if (op_i == 4'h0) p_add_inverse_r1: assert (result_o - b_i == a_i)
            else $error("R1 add inverse");
        if (op_i == 4'h2) p_sub_inverse_r1: assert (result_o + b_i == a_i)
            else $error("R1 sub inverse");
        if (op_i == 4'h1) p_ror_inverse_r2: assert (rot_back[2*DATA_W-1:DATA_W] == a_i)
            else $error("R2 rotate inverse");
        if (op_i == 4'h4) p_and_subset_r4: assert ((result_o & ~(a_i & b_i)) == '0)
            else $error("R4 and subset");
        if (op_i == 4'h8) p_shl_low_zero_r5: assert ((result_o & ~({DATA_W{1'b1}} << amt)) == '0)
            else $error("R5 left shift low bits");
        if (op_i == 4'hB) p_ins_outside_r7: assert (((result_o ^ a_i) & outside) == '0)
            else $error("R7 insert outside field");
        if (op_i == 4'hC) p_sext_uniform_r8: assert (above == '0 || above == '1)
            else $error("R8 sign fill");
        if (op_i == 4'hD) p_uext_high_zero_r9: assert ((result_o >> flen) == '0)
            else $error("R9 zero fill");
        if (op_i == 4'hE) p_flip_count_r10: assert ($countones(result_o) == $countones(a_i))
            else $error("R10 flip bit count");
        if (illegal_o) p_illegal_zero_r11: assert (result_o == '0)
            else $error("R11 illegal result");
    end
endmodule

bind bitfield_alu bitfield_alu_checker #(.DATA_W(DATA_W)) u_checker (
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .result_o  (result_o),
    .illegal_o (illegal_o)
);

// File: tb/test_bitfield_alu.sv
`timescale 1ns/1ps
module test_bitfield_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op;
    logic [31:0] a, b;
    logic [31:0] result;
    logic        illegal;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bitfield_alu i_bitfield_alu (
        .op_i(op), .a_i(a), .b_i(b), .result_o(result), .illegal_o(illegal)
    );

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'h0, 4'h2: return "R1";
            4'h1:       return "R2";
            4'h3:       return "R3";
            4'h4, 4'h5, 4'h6, 4'h7: return "R4";
            4'h8, 4'h9, 4'hA: return "R5";
            4'hB:       return "R7/R6";
            4'hC:       return "R8/R6";
            4'hD:       return "R9/R6";
            4'hE:       return "R10";
            default:    return "R11";
        endcase
    endfunction

    // Bit-level reference model written from the requirements.
    function automatic logic [32:0] model(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] r;
        logic [31:0] t;
        int amt, pos, len;
        amt = int'(y[4:0]);
        pos = amt;
        len = (y[8:5] == 0) ? 16 : int'(y[8:5]);
        r = '0;
        case (c)
            4'h0: r = x + y;
            4'h2: r = x - y;
            4'h1: for (int i = 0; i < 32; i++) r[i] = x[(i + amt) % 32];
            4'h3: begin r = x << 10; r[9:0] = y[9:0]; end
            4'h4: r = x & y;
            4'h5: r = x | y;
            4'h6: r = x ^ y;
            4'h7: r = ~(x ^ y);
            4'h8: for (int i = 0; i < 32; i++) r[i] = (i >= amt) ? x[i - amt] : 1'b0;
            4'h9: for (int i = 0; i < 32; i++) r[i] = (i + amt < 32) ? x[i + amt] : 1'b0;
            4'hA: for (int i = 0; i < 32; i++) r[i] = (i + amt < 32) ? x[i + amt] : x[31];
            4'hB: begin
                r = x;
                t = y >> 10;
                for (int k = 0; k < len; k++) if (pos + k < 32) r[pos + k] = t[k];
            end
            4'hC, 4'hD: begin
                for (int k = 0; k < len; k++) r[k] = (pos + k < 32) ? x[pos + k] : 1'b0;
                if (c == 4'hC) for (int k = len; k < 32; k++) r[k] = r[len - 1];
            end
            4'hE: begin
                r = x;
                for (int s = 0; s < 5; s++) if (y[s]) begin
                    t = r;
                    for (int i = 0; i < 32; i++) r[i] = t[i ^ (1 << s)];
                end
            end
            default: return {1'b1, 32'h0};
        endcase
        return {1'b0, r};
    endfunction

    task automatic apply(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y, input string req);
        logic [32:0] exp;
        @(posedge clk);
        op = c; a = x; b = y;
        @(negedge clk);
        exp = model(c, x, y);
        n_vec++;
        if (result !== exp[31:0] || illegal !== exp[32]) begin
            n_bad++;
            $display("FAIL %s op=%h a=%h b=%h actual=%h/%b expected=%h/%b",
                     req, c, x, y, result, illegal, exp[31:0], exp[32]);
        end
    endtask

    initial begin
        op = 4'h0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        // Reset state: zero operands give a zero sum and no illegal flag (R1, R11).
        @(negedge clk);
        n_vec++;
        if (result !== 32'h0 || illegal !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset actual=%h/%b expected=00000000/0", result, illegal);
        end
        rst_n = 1'b1;

        apply(4'h0, 32'hFFFF_FFFF, 32'h1, "R1");            // add wraps
        apply(4'h2, 32'h0, 32'h1, "R1");                    // subtract wraps
        apply(4'h1, 32'h1234_5678, 32'hFFFF_FFE0, "R2");    // amount 0, upper B ignored
        apply(4'h1, 32'h8000_0001, 32'h0000_001F, "R2");
        apply(4'h3, 32'h003F_FFFF, 32'hFFFF_FC00, "R3");
        apply(4'h3, 32'hABCD_0123, 32'h0000_03FF, "R3");
        apply(4'h7, 32'hF0F0_F0F0, 32'h0FF0_0FF0, "R4");
        apply(4'h8, 32'hDEAD_BEEF, 32'h0000_0020, "R5");    // amount is B[4:0]=0
        apply(4'hA, 32'h8000_0000, 32'h0000_001F, "R5");
        apply(4'h9, 32'h8000_0000, 32'h0000_001F, "R5");
        apply(4'hD, 32'hFFFF_FFFF, 32'h0000_0004, "R6");    // len code 0 -> 16 bits
        apply(4'hD, 32'hFFFF_FFFF, 32'h0000_003C, "R6");    // len 1, pos 28
        apply(4'hB, 32'h0000_0000, 32'hFFFF_FC00 | (32'd0 << 5) | 32'd31, "R7"); // crosses top
        apply(4'hB, 32'hFFFF_FFFF, 32'h0000_0000 | (32'd4 << 5) | 32'd8, "R7");
        apply(4'hC, 32'h0000_0080, 32'h0000_0000 | (32'd8 << 5), "R8");
        apply(4'hC, 32'h8000_0000, 32'h0000_001F, "R8");    // field past bit 31
        apply(4'hD, 32'h0000_F000, 32'h0000_0000 | (32'd4 << 5) | 32'd12, "R9");
        apply(4'hE, 32'h0000_0001, 32'h0000_001F, "R10");   // full reversal
        apply(4'hE, 32'h1234_5678, 32'hFFFF_FFE0, "R10");   // no stage enabled
        apply(4'hE, 32'h1234_5678, 32'h0000_0018, "R10");   // byte and half-word swap
        apply(4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11");

        void'($urandom(32'h0A1B_2C3D));
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] c;
            c = 4'($urandom_range(15, 0));
            apply(c, $urandom, $urandom, req_of(c));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule